// File: doc/BRIEF.md
# Interrupt Pending Vector and Delivery Gate

This block holds the eight-line interrupt-pending vector of a processor's control coprocessor and decides whether the core should take an interrupt. Each line can be raised or dropped by a numbered request. The whole vector can be wiped in one strobe. A count/compare timer match raises a line chosen by a programmable 3-bit slot field. The block reads the status enable, error-level, exception-level and mask fields as inputs. From these and the pending vector it forms a registered take-interrupt request and a separate any-pending flag.

A request carries a 2-bit operation code and an 8-bit two's-complement line number. A line number outside 0..7 is rejected: the vector is left alone and a one-cycle error pulse follows. The wipe strobe, a line request and a timer match may all arrive in the same cycle. They are then merged in a fixed order: wipe first, then the line request, then the timer injection.

Top module: `irq_pending_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pend_vec`, `irq_take` and `req_err` are all cleared to zero.
- R2: `req_op` = 2'b01 (post) with a legal `req_line` n in 0..7 sets `pend_vec[n]` at the next edge, and no other bit changes.
- R3: `req_op` = 2'b10 (drop) with a legal `req_line` n clears `pend_vec[n]` at the next edge, and no other bit changes. Codes 2'b00 and 2'b11 do nothing.
- R4: `wipe_all` clears the whole vector at the next edge. When a post arrives in the same cycle, the result holds only the posted bit.
- R5: A post or drop whose `req_line` (two's complement) is negative or at least 8 leaves `pend_vec` unchanged. `req_err` is then high for exactly the cycle after that edge; otherwise `req_err` is low.
- R6: A timer match occurs when `cmp_val` equals `cnt_val` and `cnt_val` is nonzero. It sets `pend_vec[tmr_slot]` at the next edge. When `cnt_val` is zero, equal values do nothing.
- R7: A timer injection is applied after the wipe and after the line request of the same cycle. A drop or wipe that hits the injected bit therefore leaves that bit set.
- R8: `irq_take` is registered. It is high one edge after a cycle in which `st_ie`=1, `st_erl`=0, `st_exl`=0 and `st_mask & pend_vec` is nonzero.
- R9: If `st_erl` or `st_exl` is 1, or `st_ie` is 0, `irq_take` is low at the next edge whatever the mask and vector hold.
- R10: `any_pend` is combinational. It is high when `pend_vec`, OR'd with the bit a current timer match would inject, is nonzero, and it does not depend on the status fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_op | input | 2 | 01 post, 10 drop, 00/11 none |
| req_line | input | 8 | Target line, two's complement |
| wipe_all | input | 1 | Clear whole vector |
| cnt_val | input | 32 | Timer count value |
| cmp_val | input | 32 | Timer compare value |
| tmr_slot | input | 3 | Line raised on a timer match |
| st_ie | input | 1 | Global interrupt enable |
| st_erl | input | 1 | Error level |
| st_exl | input | 1 | Exception level |
| st_mask | input | 8 | Per-line delivery mask |
| pend_vec | output | 8 | Pending vector |
| any_pend | output | 1 | Any line pending, timer included |
| irq_take | output | 1 | Take-interrupt request |
| req_err | output | 1 | Illegal line number pulse |

## Verification
A line request, the wipe strobe and a timer match can all land on the same edge. The hardest case is a timer match on the same line that a drop or wipe targets. Directed cycles build these collisions deliberately, using equal nonzero count and compare values together with a drop or wipe on the slot line. Random cycles draw count and compare from a tiny range so that such collisions recur often. A bench model applies the merge order wipe, request, timer and predicts the vector one edge later. It also predicts `irq_take` from the model vector and the status fields of the previous cycle.

// File: rtl/irq_pkg.sv
// Shared definitions for the interrupt pending unit.
// Assumes eight lines unless a user overrides the parameters of the top.
package irq_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_POST = 2'b01,
        OP_DROP = 2'b10,
        OP_RSVD = 2'b11
    } irq_op_e;
endpackage

// File: rtl/irq_req_decode.sv
// Turns a numbered line request into one-hot set and clear masks.
// Assumes req_line is two's complement; out-of-range numbers give no mask
// and flag an illegal request instead.
module irq_req_decode #(
    parameter int NUM_LINES = 8,
    parameter int LINE_W    = 8
) (
    input  logic [1:0]           req_op,
    input  logic [LINE_W-1:0]    req_line,
    output logic [NUM_LINES-1:0] set_mask,
    output logic [NUM_LINES-1:0] clr_mask,
    output logic                 bad_req
);
    import irq_pkg::*;
    localparam int MAG_W = LINE_W - 1;

    logic    in_range;
    irq_op_e op;

    // Classify the request and check the line number range.
    always_comb begin
        op       = irq_op_e'(req_op);
        in_range = !req_line[LINE_W-1] &&
                   (req_line[MAG_W-1:0] < MAG_W'(NUM_LINES));
        bad_req  = ((op == OP_POST) || (op == OP_DROP)) && !in_range;
    end

    // Build one-hot masks, one bit per line.
    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            assign set_mask[g] = (op == OP_POST) && in_range &&
                                 (req_line[MAG_W-1:0] == MAG_W'(g));
            assign clr_mask[g] = (op == OP_DROP) && in_range &&
                                 (req_line[MAG_W-1:0] == MAG_W'(g));
        end
    endgenerate
endmodule

// File: rtl/irq_timer_match.sv
// Detects a count/compare match and turns it into a one-hot injection at
// the programmed slot. Assumes a zero count never counts as a match.
module irq_timer_match #(
    parameter int NUM_LINES = 8,
    parameter int TMR_W     = 32,
    parameter int SLOT_W    = $clog2(NUM_LINES)
) (
    input  logic [TMR_W-1:0]     cnt_val,
    input  logic [TMR_W-1:0]     cmp_val,
    input  logic [SLOT_W-1:0]    tmr_slot,
    output logic [NUM_LINES-1:0] inject
);
    logic hit;

    // Match only on equal values with a nonzero count.
    always_comb hit = (cnt_val == cmp_val) && (cnt_val != '0);

    // Steer the match to the selected line.
    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_inj
            assign inject[g] = hit && (tmr_slot == SLOT_W'(g));
        end
    endgenerate
endmodule

// File: rtl/irq_pend_reg.sv
// Holds the pending vector; merges wipe, line request and timer injection
// in that order on one edge. Assumes set and clear masks never overlap.
module irq_pend_reg #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wipe_all,
    input  logic [NUM_LINES-1:0] set_mask,
    input  logic [NUM_LINES-1:0] clr_mask,
    input  logic [NUM_LINES-1:0] inject,
    input  logic                 bad_req,
    output logic [NUM_LINES-1:0] pend_q
);
    logic [NUM_LINES-1:0] base, nxt;

    // Apply wipe, then request, then timer.
    always_comb begin
        base = wipe_all ? '0 : pend_q;
        nxt  = ((base | set_mask) & ~clr_mask) | inject;
    end

    // Register the vector.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= nxt;
    end

    AST_BAD_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_req && !wipe_all && inject == '0) |=> pend_q == $past(pend_q)); // R5
    AST_POST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0) |=> (pend_q & $past(set_mask)) == $past(set_mask)); // R2
    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0 && (clr_mask & inject) == '0) |=> (pend_q & $past(clr_mask)) == '0); // R3
    AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (wipe_all && set_mask == '0 && inject == '0) |=> pend_q == '0); // R4
    AST_TIMER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (inject != '0) |=> (pend_q & $past(inject)) == $past(inject)); // R7
    AST_INJECT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inject)); // R6
endmodule

// File: rtl/irq_gate.sv
// Forms the registered take-interrupt request from the status gating and
// the masked pending vector. Assumes mask and vector align bit for bit.
module irq_gate #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 st_ie,
    input  logic                 st_erl,
    input  logic                 st_exl,
    input  logic [NUM_LINES-1:0] st_mask,
    input  logic [NUM_LINES-1:0] pend_q,
    output logic                 irq_q
);
    logic allow, hit;

    // Gate on enable and both level bits, then look for overlap.
    always_comb begin
        allow = st_ie && !st_erl && !st_exl;
        hit   = |(st_mask & pend_q);
    end

    // Register the request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= allow && hit;
    end

    AST_LEVEL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_erl || st_exl || !st_ie) |=> !irq_q); // R9
    AST_NO_OVERLAP_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_mask & pend_q) == '0) |=> !irq_q); // R8
endmodule

// File: rtl/irq_pending_unit.sv
// Top of the interrupt pending unit: request decode, timer match, pending
// register and delivery gate. Assumes synchronous active-low reset.
module irq_pending_unit #(
    parameter int NUM_LINES = 8,
    parameter int LINE_W    = 8,
    parameter int TMR_W     = 32,
    parameter int SLOT_W    = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           req_op,
    input  logic [LINE_W-1:0]    req_line,
    input  logic                 wipe_all,
    input  logic [TMR_W-1:0]     cnt_val,
    input  logic [TMR_W-1:0]     cmp_val,
    input  logic [SLOT_W-1:0]    tmr_slot,
    input  logic                 st_ie,
    input  logic                 st_erl,
    input  logic                 st_exl,
    input  logic [NUM_LINES-1:0] st_mask,
    output logic [NUM_LINES-1:0] pend_vec,
    output logic                 any_pend,
    output logic                 irq_take,
    output logic                 req_err
);
    logic [NUM_LINES-1:0] set_mask, clr_mask, inject;
    logic                 bad_req;

    irq_req_decode #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_dec (
        .req_op(req_op), .req_line(req_line),
        .set_mask(set_mask), .clr_mask(clr_mask), .bad_req(bad_req));

    irq_timer_match #(.NUM_LINES(NUM_LINES), .TMR_W(TMR_W), .SLOT_W(SLOT_W)) u_tmr (
        .cnt_val(cnt_val), .cmp_val(cmp_val), .tmr_slot(tmr_slot), .inject(inject));

    irq_pend_reg #(.NUM_LINES(NUM_LINES)) u_pend (
        .clk(clk), .rst_n(rst_n), .wipe_all(wipe_all), .set_mask(set_mask),
        .clr_mask(clr_mask), .inject(inject), .bad_req(bad_req), .pend_q(pend_vec));

    irq_gate #(.NUM_LINES(NUM_LINES)) u_gate (
        .clk(clk), .rst_n(rst_n), .st_ie(st_ie), .st_erl(st_erl), .st_exl(st_exl),
        .st_mask(st_mask), .pend_q(pend_vec), .irq_q(irq_take));

    // Flag an illegal line number for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) req_err <= 1'b0;
        else        req_err <= bad_req;
    end

    // Summarise pending lines including a match in progress.
    always_comb any_pend = |(pend_vec | inject);

    AST_ERR_FROM_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> $past(bad_req)); // R5
    AST_ANY_COVERS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec != '0) |-> any_pend); // R10
endmodule

// File: tb/irq_pending_unit_test.sv
module irq_pending_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [7:0]  req_line = 8'd0;
    logic        wipe_all = 1'b0;
    logic [31:0] cnt_val = 32'd0, cmp_val = 32'd1;
    logic [2:0]  tmr_slot = 3'd0;
    logic        st_ie = 1'b0, st_erl = 1'b0, st_exl = 1'b0;
    logic [7:0]  st_mask = 8'h00;
    logic [7:0]  pend_vec;
    logic        any_pend, irq_take, req_err;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] m_pend = 8'h00;
    logic       m_irq = 1'b0, m_err = 1'b0;

    always #2 clk = ~clk;

    irq_pending_unit uut (
        .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_line(req_line),
        .wipe_all(wipe_all), .cnt_val(cnt_val), .cmp_val(cmp_val),
        .tmr_slot(tmr_slot), .st_ie(st_ie), .st_erl(st_erl), .st_exl(st_exl),
        .st_mask(st_mask), .pend_vec(pend_vec), .any_pend(any_pend),
        .irq_take(irq_take), .req_err(req_err));

    function automatic logic [7:0] f_inject();
        if (cnt_val == cmp_val && cnt_val != 0) return 8'h01 << tmr_slot;
        return 8'h00;
    endfunction

    function automatic logic f_legal();
        return ($signed(req_line) >= 0) && ($signed(req_line) < 8);
    endfunction

    function automatic logic [7:0] f_next(logic [7:0] cur);
        logic [7:0] v;
        v = wipe_all ? 8'h00 : cur;
        if (f_legal() && req_op == 2'b01) v = v | (8'h01 << req_line[2:0]);
        if (f_legal() && req_op == 2'b10) v = v & ~(8'h01 << req_line[2:0]);
        return v | f_inject();
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Inputs are set at a negedge; check any_pend, advance one edge, check state.
    task automatic step(string tag);
        #1 chk({tag, " R10 any_pend"}, {7'd0, any_pend}, {7'd0, |(m_pend | f_inject())});
        m_irq  = st_ie && !st_erl && !st_exl && |(st_mask & m_pend);
        m_err  = (req_op == 2'b01 || req_op == 2'b10) && !f_legal();
        m_pend = f_next(m_pend);
        @(negedge clk);
        chk({tag, " pend_vec"}, pend_vec, m_pend);
        chk({tag, " R8 R9 irq_take"}, {7'd0, irq_take}, {7'd0, m_irq});
        chk({tag, " R5 req_err"}, {7'd0, req_err}, {7'd0, m_err});
        req_op = 2'b00; wipe_all = 1'b0; cnt_val = 32'd0; cmp_val = 32'd1;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pend", pend_vec, 8'h00);
        chk("R1 irq", {7'd0, irq_take}, 8'h00);
        chk("R1 err", {7'd0, req_err}, 8'h00);
        rst_n = 1'b1;

        req_op = 2'b01; req_line = 8'd3; step("R2 post 3");
        req_op = 2'b01; req_line = 8'd7; step("R2 post 7");
        req_op = 2'b10; req_line = 8'd3; step("R3 drop 3");
        req_op = 2'b11; req_line = 8'd7; step("R3 reserved op");
        req_op = 2'b01; req_line = 8'd8; step("R5 line 8");
        req_op = 2'b10; req_line = 8'hFF; step("R5 line -1");
        wipe_all = 1'b1; req_op = 2'b01; req_line = 8'd1; step("R4 wipe+post");
        wipe_all = 1'b1; step("R4 wipe");
        cnt_val = 0; cmp_val = 0; tmr_slot = 3'd5; step("R6 zero count");
        cnt_val = 9; cmp_val = 9; tmr_slot = 3'd5; step("R6 match");
        cnt_val = 4; cmp_val = 4; tmr_slot = 3'd5; req_op = 2'b10; req_line = 8'd5;
        step("R7 drop vs timer");
        cnt_val = 4; cmp_val = 4; tmr_slot = 3'd2; wipe_all = 1'b1; step("R7 wipe vs timer");
        st_ie = 1; st_mask = 8'h04; step("R8 gate open");
        step("R8 held");
        st_erl = 1; step("R9 erl");
        st_erl = 0; st_exl = 1; step("R9 exl");
        st_exl = 0; st_ie = 0; step("R9 ie off");

        for (int i = 0; i < 3000; i++) begin
            int k;
            k = $urandom % 8;
            req_op   = 2'($urandom);
            req_line = 8'($signed($urandom % 14) - 3);
            wipe_all = ($urandom % 10) == 0;
            cnt_val  = 32'($urandom % 3);
            cmp_val  = 32'($urandom % 3);
            tmr_slot = 3'($urandom);
            st_ie    = k != 0;
            st_erl   = k == 1;
            st_exl   = k == 2;
            st_mask  = 8'($urandom);
            if (k == 3) rst_n = 1'b0;
            if (!rst_n) begin
                @(negedge clk);
                rst_n = 1'b1;
                m_pend = 0; m_irq = 0; m_err = 0;
                chk("R1 rand reset pend", pend_vec, 8'h00);
                chk("R1 rand reset irq", {7'd0, irq_take}, 8'h00);
            end else begin
                step("rand R2 R3 R4 R6 R7");
            end
        end
        finish_up();
    end
endmodule